// File: doc/BRIEF.md
# Command-Driven Status and Error Flag Register

This block holds the run state of a serial controller: a run-enable bit, a master-select bit and six sticky error flags (transmit overflow, receive overflow, abort, transmit underflow, receive underflow and mode error). Software never writes the status bits directly. It writes a command word in which every bit has a separate set bit and clear bit. Hardware event pulses from the serial engine raise the error flags. A control register holds a per-kind enable for five of the error kinds, and an interrupt mask gates four request lines. One of those lines is the error interrupt, which the block derives from the error flags.

Turning the module off, which puts it into configuration mode, only takes effect while the engine reports idle. A clear-enable command that arrives while the engine is busy is held pending. It completes on the first clock edge at which busy is low.

The register port is a plain single-cycle write strobe with a combinational read mux. It has no handshake and applies no back-pressure.

Top module: `sr_status_unit`

## Requirements
- R1: After reset, run enable, master select, all six error flags, the control enables and the interrupt mask are 0, and every interrupt output is low.
- R2: A command write (address 2) with bit1 set turns run enable on, and bit0 turns it off. Bit3 sets master select and bit2 clears it. Status bit0 shows run enable and status bit1 shows master select.
- R3: Command bits 12..15 set the transmit-overflow, receive-overflow, abort and transmit-underflow flags, and bits 8..11 clear them in the same order. Bit5 sets receive underflow and bit4 clears it. Bit7 sets mode error and bit6 clears it.
- R4: When a command word carries both the set bit and the clear bit of the same status bit, the result is cleared.
- R5: The command value 0x0F50 clears all six error flags in one write.
- R6: A run-enable clear takes effect only at a clock edge where engine_busy is low. While busy stays high, run enable remains 1. A later set-enable command cancels a pending clear.
- R7: The event vector err_evt carries bit0 transmit overflow, bit1 receive overflow, bit2 abort, bit3 transmit underflow, bit4 receive underflow and bit5 mode error. Events 0..4 set their flag only when the matching control bit (address 0, bits 8..12 in the same order) is 1. A mode-error event always sets its flag.
- R8: Error flags are sticky and hold until a command clears them. A hardware event in the same cycle as a clear command leaves the flag set.
- R9: Status (address 1) reads bit0 enable, bit1 master select, bit7 mode error, bits 8..12 the five other flags in R7 order, and bit13 the live engine_busy input. All other bits read 0.
- R10: irq_out bit0 is rx_req, bit1 is tx_req and bit3 is frame_req, each ANDed with the matching bit of the mask (address 3, bits 3:0). irq_out bit2 is mask bit2 ANDed with the condition that some flag is set whose control enable is 1, or that mode error is set.
- R11: A write to the status address is ignored, and the command address always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 command, 3 mask |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| engine_busy | input | 1 | Serial engine transfer in progress |
| err_evt | input | 6 | Error event pulses (R7 order) |
| rx_req | input | 1 | Receive interrupt request |
| tx_req | input | 1 | Transmit interrupt request |
| frame_req | input | 1 | Frame-end interrupt request |
| irq_out | output | 4 | Gated interrupt lines |
| run_en | output | 1 | Run enable (0 = configuration mode) |
| master_sel | output | 1 | Master select |

## Verification
A flag cell that latched wrongly shows up in the status read and on irq_out bit2 one clock after the write or event that caused it. The bench therefore compares the read port, the interrupt vector and both mode outputs against a reference model on every clock. A lost pending disable appears as run_en staying high one cycle after busy falls. A disable that skips the pending state appears as run_en dropping while busy is still high. A set/clear priority error appears on the read after one write.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int ERR_KINDS = 5;
  localparam int FLAG_N    = ERR_KINDS + 1;
  localparam int CTRL_LSB  = 8;
  localparam int STAT_EN   = 0;
  localparam int STAT_MS   = 1;
  localparam int STAT_MODE = 7;
  localparam int STAT_ERR  = 8;
  localparam int STAT_BUSY = 13;
  localparam int CMD_EN_CLR = 0;
  localparam int CMD_EN_SET = 1;
  localparam int CMD_MS_CLR = 2;
  localparam int CMD_MS_SET = 3;
  localparam int IRQ_ERR_LINE = 2;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_CMD  = 2'd2,
    A_MASK = 2'd3
  } sr_addr_e;

  function automatic int clr_pos(input int f);
    case (f)
      0: return 8;
      1: return 9;
      2: return 10;
      3: return 11;
      4: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int set_pos(input int f);
    case (f)
      0: return 12;
      1: return 13;
      2: return 14;
      3: return 15;
      4: return 5;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/sr_flag_cell.sv
module sr_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_cmd,
  input  logic clr_cmd,
  input  logic hw_evt,
  input  logic hw_en,
  output logic flag_q
);
  // priority: enabled hardware event, then clear, then set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              flag_q <= 1'b0;
    else if (hw_evt && hw_en) flag_q <= 1'b1;
    else if (clr_cmd)        flag_q <= 1'b0;
    else if (set_cmd)        flag_q <= 1'b1;
  end
endmodule

// File: rtl/sr_run_ctrl.sv
module sr_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_clr,
  input  logic en_set,
  input  logic ms_clr,
  input  logic ms_set,
  input  logic busy,
  output logic run_en,
  output logic master_sel
);
  logic pend_q, pend_n, en_n;

  always_comb begin
    pend_n = pend_q;
    en_n   = run_en;
    if (en_clr) begin
      pend_n = 1'b1;
    end else if (en_set) begin
      pend_n = 1'b0;
      en_n   = 1'b1;
    end
    if (pend_n && !busy) begin
      en_n   = 1'b0;
      pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      run_en     <= 1'b0;
      master_sel <= 1'b0;
    end else begin
      pend_q <= pend_n;
      run_en <= en_n;
      if (ms_clr)      master_sel <= 1'b0;
      else if (ms_set) master_sel <= 1'b1;
    end
  end
endmodule

// File: rtl/sr_irq_gate.sv
module sr_irq_gate #(
  parameter int IRQ_N    = 4,
  parameter int ERR_LINE = 2
) (
  input  logic [IRQ_N-1:0] req_in,
  input  logic [IRQ_N-1:0] mask,
  input  logic             err_active,
  output logic [IRQ_N-1:0] irq
);
  logic [IRQ_N-1:0] src;
  always_comb begin
    src           = req_in;
    src[ERR_LINE] = err_active;
    irq           = src & mask;
  end
endmodule

// File: rtl/sr_status_unit.sv
module sr_status_unit
  import sr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IRQ_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              engine_busy,
  input  logic [FLAG_N-1:0] err_evt,
  input  logic              rx_req,
  input  logic              tx_req,
  input  logic              frame_req,
  output logic [IRQ_N-1:0]  irq_out,
  output logic              run_en,
  output logic              master_sel
);
  localparam int MODE_IDX = FLAG_N - 1;

  logic [ERR_KINDS-1:0] ctrl_q;
  logic [IRQ_N-1:0]     mask_q;
  logic [FLAG_N-1:0]    flags_q;
  logic                 cmd_wr;
  logic                 err_active;
  logic [IRQ_N-1:0]     req_vec;

  assign cmd_wr = bus_wr && (bus_addr == A_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) ctrl_q <= bus_wdata[CTRL_LSB +: ERR_KINDS];
      if (bus_addr == A_MASK) mask_q <= bus_wdata[IRQ_N-1:0];
    end
  end

  for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
    logic evt_en;
    if (f == MODE_IDX) begin : g_always
      assign evt_en = 1'b1;
    end else begin : g_gated
      assign evt_en = ctrl_q[f];
    end
    sr_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_cmd(cmd_wr && bus_wdata[set_pos(f)]),
      .clr_cmd(cmd_wr && bus_wdata[clr_pos(f)]),
      .hw_evt (err_evt[f]),
      .hw_en  (evt_en),
      .flag_q (flags_q[f])
    );
  end

  sr_run_ctrl u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_clr    (cmd_wr && bus_wdata[CMD_EN_CLR]),
    .en_set    (cmd_wr && bus_wdata[CMD_EN_SET]),
    .ms_clr    (cmd_wr && bus_wdata[CMD_MS_CLR]),
    .ms_set    (cmd_wr && bus_wdata[CMD_MS_SET]),
    .busy      (engine_busy),
    .run_en    (run_en),
    .master_sel(master_sel)
  );

  assign err_active = (|(flags_q[ERR_KINDS-1:0] & ctrl_q)) | flags_q[MODE_IDX];
  assign req_vec    = {frame_req, 1'b0, tx_req, rx_req};

  sr_irq_gate #(.IRQ_N(IRQ_N), .ERR_LINE(IRQ_ERR_LINE)) u_irq (
    .req_in    (req_vec),
    .mask      (mask_q),
    .err_active(err_active),
    .irq       (irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[CTRL_LSB +: ERR_KINDS] = ctrl_q;
      A_STAT: begin
        bus_rdata[STAT_EN]                   = run_en;
        bus_rdata[STAT_MS]                   = master_sel;
        bus_rdata[STAT_MODE]                 = flags_q[MODE_IDX];
        bus_rdata[STAT_ERR +: ERR_KINDS]     = flags_q[ERR_KINDS-1:0];
        bus_rdata[STAT_BUSY]                 = engine_busy;
      end
      A_MASK: bus_rdata[IRQ_N-1:0] = mask_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sr_status_chk.sv
module sr_status_chk
  import sr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        engine_busy,
  input logic [5:0]  err_evt,
  input logic        run_en,
  input logic [3:0]  irq_out,
  input logic [5:0]  flags,
  input logic [4:0]  ctrl,
  input logic [3:0]  mask
);
  logic cmd_wr;
  assign cmd_wr = bus_wr && (bus_addr == A_CMD);

  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[4] && bus_wdata[5] && !err_evt[4]) |=> !flags[4]);

  a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata == 16'h0F50 && err_evt == 6'd0) |=> (flags == 6'd0));

  a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && engine_busy) |=> run_en);

  a_r7_masked_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !flags[0] && !(cmd_wr && bus_wdata[12])) |=> !flags[0]);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !(cmd_wr && bus_wdata[8])) |=> flags[0]);

  a_r10_err_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out[2] |-> mask[2]);
endmodule

bind sr_status_unit sr_status_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .engine_busy(engine_busy),
  .err_evt    (err_evt),
  .run_en     (run_en),
  .irq_out    (irq_out),
  .flags      (flags_q),
  .ctrl       (ctrl_q),
  .mask       (mask_q)
);

// File: tb/tb_sr_status_unit.sv
`timescale 1ns/1ps
module tb_sr_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        engine_busy = 1'b0;
  logic [5:0]  err_evt = 6'd0;
  logic        rx_req = 1'b0, tx_req = 1'b0, frame_req = 1'b0;
  logic [3:0]  irq_out;
  logic        run_en, master_sel;

  int n_checks = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  sr_status_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .engine_busy(engine_busy),
    .err_evt(err_evt), .rx_req(rx_req), .tx_req(tx_req), .frame_req(frame_req),
    .irq_out(irq_out), .run_en(run_en), .master_sel(master_sel)
  );

  // behavioural reference model
  bit       m_en, m_ms, m_pend;
  bit [5:0] m_flag;
  bit [4:0] m_ctrl;
  bit [3:0] m_mask;
  int clr_bit[6] = '{8, 9, 10, 11, 4, 6};
  int set_bit[6] = '{12, 13, 14, 15, 5, 7};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_ms = 0; m_pend = 0; m_flag = 0; m_ctrl = 0; m_mask = 0;
    end else begin
      bit cw, np;
      bit [4:0] old_ctrl;
      old_ctrl = m_ctrl;
      cw = bus_wr && bus_addr == 2'd2;
      for (int f = 0; f < 6; f++) begin
        if (err_evt[f] && (f == 5 || old_ctrl[f])) m_flag[f] = 1;
        else if (cw && bus_wdata[clr_bit[f]]) m_flag[f] = 0;
        else if (cw && bus_wdata[set_bit[f]]) m_flag[f] = 1;
      end
      np = m_pend;
      if (cw && bus_wdata[0]) np = 1;
      else if (cw && bus_wdata[1]) begin np = 0; m_en = 1; end
      if (np && !engine_busy) begin m_en = 0; np = 0; end
      m_pend = np;
      if (cw && bus_wdata[2]) m_ms = 0;
      else if (cw && bus_wdata[3]) m_ms = 1;
      if (bus_wr && bus_addr == 2'd0) m_ctrl = bus_wdata[12:8];
      if (bus_wr && bus_addr == 2'd3) m_mask = bus_wdata[3:0];
    end
  end

  function automatic logic [15:0] m_read(input logic [1:0] a);
    logic [15:0] r = 16'd0;
    case (a)
      2'd0: r[12:8] = m_ctrl;
      2'd1: begin
        r[0] = m_en; r[1] = m_ms; r[7] = m_flag[5];
        r[12:8] = m_flag[4:0]; r[13] = engine_busy;
      end
      2'd3: r[3:0] = m_mask;
      default: r = 16'd0;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] m_irq();
    logic [3:0] v;
    v[0] = rx_req & m_mask[0];
    v[1] = tx_req & m_mask[1];
    v[3] = frame_req & m_mask[3];
    v[2] = m_mask[2] & ((|(m_flag[4:0] & m_ctrl)) | m_flag[5]);
    return v;
  endfunction

  always @(negedge clk) begin
    if (cmp_on) begin
      n_checks += 3;
      if (bus_rdata !== m_read(bus_addr)) begin
        n_fail++;
        $display("FAIL R9 model rdata addr %0d: got %h exp %h", bus_addr, bus_rdata, m_read(bus_addr));
      end
      if (irq_out !== m_irq()) begin
        n_fail++;
        $display("FAIL R10 model irq: got %b exp %b", irq_out, m_irq());
      end
      if (run_en !== m_en || master_sel !== m_ms) begin
        n_fail++;
        $display("FAIL R6 model en/ms: got %b%b exp %b%b", run_en, master_sel, m_en, m_ms);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic chk_rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    n_checks++;
    if (bus_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s addr %0d: got %h exp %h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic [3:0] exp, input string tag);
    @(negedge clk);
    n_checks++;
    if (irq_out !== exp) begin
      n_fail++;
      $display("FAIL %s irq: got %b exp %b", tag, irq_out, exp);
    end
  endtask

  task automatic pulse(input logic [5:0] v);
    @(posedge clk); #1; err_evt = v;
    @(posedge clk); #1; err_evt = 6'd0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; cmp_on = 1;
    // R1 reset state
    chk_rd(2'd1, 16'h0000, "R1 status");
    chk_rd(2'd0, 16'h0000, "R1 ctrl");
    chk_rd(2'd3, 16'h0000, "R1 mask");
    chk_irq(4'b0000, "R1");
    // R2 enable / master select
    wr(2'd2, 16'h0002); chk_rd(2'd1, 16'h0001, "R2 set en");
    wr(2'd2, 16'h0008); chk_rd(2'd1, 16'h0003, "R2 set ms");
    wr(2'd2, 16'h0004); chk_rd(2'd1, 16'h0001, "R2 clr ms");
    // R3 set all flags via command
    wr(2'd2, 16'hF0A0); chk_rd(2'd1, 16'h1F81, "R3 set all");
    wr(2'd2, 16'h0200); chk_rd(2'd1, 16'h1D81, "R3 clr rx ovf");
    // R5 clear all
    wr(2'd2, 16'h0F50); chk_rd(2'd1, 16'h0001, "R5 clear all");
    // R4 clear wins
    wr(2'd2, 16'h0030); chk_rd(2'd1, 16'h0001, "R4 rx udf");
    wr(2'd2, 16'h0003); chk_rd(2'd1, 16'h0000, "R4 enable");
    wr(2'd2, 16'h0002); chk_rd(2'd1, 16'h0001, "R4 re-enable");
    // R7 event gating
    pulse(6'b011111); chk_rd(2'd1, 16'h0001, "R7 disabled kinds");
    pulse(6'b100000); chk_rd(2'd1, 16'h0081, "R7 mode error");
    wr(2'd2, 16'h0040); chk_rd(2'd1, 16'h0001, "R3 clr mode");
    wr(2'd0, 16'h1F00); chk_rd(2'd0, 16'h1F00, "R7 ctrl");
    pulse(6'b000101); chk_rd(2'd1, 16'h0501, "R7 enabled kinds");
    // R8 sticky
    repeat (3) @(posedge clk);
    #1 chk_rd(2'd1, 16'h0501, "R8 sticky");
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = 2'd2; bus_wdata = 16'h0100; err_evt = 6'b000001;
    @(posedge clk); #1;
    bus_wr = 0; err_evt = 6'd0;
    chk_rd(2'd1, 16'h0501, "R8 event beats clear");
    wr(2'd2, 16'h0F50); chk_rd(2'd1, 16'h0001, "R5 clear again");
    // R10 interrupts
    wr(2'd3, 16'h0004); chk_rd(2'd3, 16'h0004, "R10 mask");
    wr(2'd2, 16'h1000); chk_irq(4'b0100, "R10 err on");
    wr(2'd0, 16'h0000); chk_irq(4'b0000, "R10 kind disabled");
    chk_rd(2'd1, 16'h0101, "R8 flag kept");
    wr(2'd0, 16'h1F00); chk_irq(4'b0100, "R10 kind re-enabled");
    wr(2'd3, 16'h000F);
    rx_req = 1; tx_req = 1; frame_req = 1;
    chk_irq(4'b1111, "R10 all");
    rx_req = 0; tx_req = 0; frame_req = 0;
    chk_irq(4'b0100, "R10 err only");
    wr(2'd3, 16'h000B); chk_irq(4'b0000, "R10 err masked");
    wr(2'd3, 16'h000F);
    wr(2'd2, 16'h0F50); chk_irq(4'b0000, "R10 cleared");
    // R6 busy-gated disable
    @(posedge clk); #1 engine_busy = 1;
    wr(2'd2, 16'h0001); chk_rd(2'd1, 16'h2001, "R6 pending");
    repeat (3) @(posedge clk);
    #1 chk_rd(2'd1, 16'h2001, "R6 still busy");
    @(posedge clk); #1 engine_busy = 0;
    chk_rd(2'd1, 16'h0001, "R6 before edge");
    @(posedge clk); #1;
    chk_rd(2'd1, 16'h0000, "R6 disabled");
    wr(2'd2, 16'h0002);
    @(posedge clk); #1 engine_busy = 1;
    wr(2'd2, 16'h0001);
    wr(2'd2, 16'h0002);
    @(posedge clk); #1 engine_busy = 0;
    repeat (2) @(posedge clk);
    #1 chk_rd(2'd1, 16'h0001, "R6 cancel");
    // R11
    wr(2'd1, 16'hFFFF); chk_rd(2'd1, 16'h0001, "R11 status write");
    chk_rd(2'd2, 16'h0000, "R11 cmd read");
    repeat (2) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule